// File: doc/BRIEF.md
# Serial Bit-Rate Enable Generator

This block turns the system clock into the two timing strobes that a serial transmitter and receiver need. One byte-wide configuration register holds two fields. A two-bit prescaler select picks a divisor from the non-uniform set 1, 3, 4 and 13. A three-bit rate select then divides that result by a further power of two, from 1 up to 128. The receiver strobe runs at sixteen times the bit rate, which gives the receiver its oversampling. The transmit strobe marks every sixteenth receiver strobe. Because one setting drives both directions, the two always run at the same bit rate.

Software reads and writes the configuration through a simple byte port. Each write also restarts every counter in the chain, so the first period after a change is a full one. Reset selects the fastest setting. At that setting the receiver strobe is high on every clock cycle.

Top module: `uart_rate_gen`

## Requirements
- R1: Reading returns the prescaler select in bits 5:4 and the rate select in bits 2:0. Bits 7, 6 and 3 always read 0, and the values written to them are ignored.
- R2: Synchronous active-high reset clears both fields, so the register reads 0x00 and the block runs at its fastest setting.
- R3: The prescaler select chooses the divisor: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R4: A rate select value n divides the prescaler output by a further 2^n. The receiver strobe period is therefore divisor × 2^n clock cycles.
- R5: The transmit strobe occurs once for every 16 receiver strobes, in the same cycle as every sixteenth one.
- R6: A register write restarts all counters from zero on its clock edge. The first receiver strobe after the write comes in the P-th cycle after that edge, where P is the new period, and the first transmit strobe comes in the 16P-th cycle.
- R7: When the period is longer than one cycle, each strobe is high for exactly one clock cycle per period.
- R8: When the divisor is 1 and the rate select is 0, the receiver strobe is high on every clock cycle.
- R9: The same register setting sets the rate for both the receiver strobe and the transmit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes wr_data into the configuration register on this edge |
| wr_data | input | 8 | Configuration byte to write |
| rd_data | output | 8 | Current configuration byte |
| rx_en | output | 1 | Receiver oversampling strobe, 16 per bit time |
| tx_en | output | 1 | Transmit bit-rate strobe, one per bit time |

## Verification
The register is programmed with every prescaler code and with rate selects of 0, 1, 2 and 7. A separate divisor of 1, 3, 4 or 13 shows up in each measured period, and the shift by 2^n shows up on top of it. Some windows end partway through a period, so a counter that failed to restart on a write would shift every later strobe. Bytes with the unused bits set, such as 0xFF and 0xC8, show that those bits neither read back nor change the rate. The longest setting (13 × 128) runs long enough to see two transmit strobes and confirm the sixteen-to-one ratio at the widest counter values.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int DATA_W    = 8;
    localparam int PSEL_W    = 2;
    localparam int RSEL_W    = 3;
    localparam int PSEL_LSB  = 4;
    localparam int RSEL_LSB  = 0;
    localparam int PRESC_MAX = 13;
    localparam int PC_W      = $clog2(PRESC_MAX);
    localparam int DC_W      = (1 << RSEL_W) - 1;
    localparam int OSR       = 16;
    localparam int OC_W      = $clog2(OSR);

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [RSEL_W-1:0] rsel;
    } rate_cfg_t;

    // terminal count of the prescaler (divisor minus one)
    function automatic logic [PC_W-1:0] presc_last(input logic [PSEL_W-1:0] psel);
        logic [PC_W-1:0] r;
        case (psel)
            2'd0:    r = PC_W'(0);
            2'd1:    r = PC_W'(2);
            2'd2:    r = PC_W'(3);
            default: r = PC_W'(PRESC_MAX - 1);
        endcase
        return r;
    endfunction

    // terminal count of the power-of-two stage: 2^n - 1
    function automatic logic [DC_W-1:0] div_last(input logic [RSEL_W-1:0] rsel);
        logic [DC_W:0] one_hot;
        one_hot = (DC_W+1)'(1) << rsel;
        return DC_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_byte(input rate_cfg_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[PSEL_LSB +: PSEL_W] = c.psel;
        b[RSEL_LSB +: RSEL_W] = c.rsel;
        return b;
    endfunction

    function automatic rate_cfg_t byte_to_cfg(input logic [DATA_W-1:0] b);
        rate_cfg_t c;
        c.psel = b[PSEL_LSB +: PSEL_W];
        c.rsel = b[RSEL_LSB +: RSEL_W];
        return c;
    endfunction

endpackage

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg
    import brg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output rate_cfg_t     cfg,
    output logic          restart,
    output logic [DW-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr_en)
            cfg <= byte_to_cfg(wr_data);
    end

    assign restart = wr_en && !rst;
    assign rd_data = cfg_to_byte(cfg);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data == '0)); // R2

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & 8'h37))); // R1

endmodule

// File: rtl/brg_term_cnt.sv
module brg_term_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         hit
);

    logic [W-1:0] cnt;
    logic         at_last;

    assign at_last = (cnt == last);
    assign hit     = step && at_last;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= last); // R4

    AST_HIT_WRAPS: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt == '0)); // R7

endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
    import brg_pkg::*;
#(
    parameter int OVERSAMPLE = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_en,
    output logic              tx_en
);

    localparam int OS_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

    rate_cfg_t cfg;
    logic      restart;
    logic      pre_tick;

    brg_cfg_reg #(.DW(DATA_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .restart (restart),
        .rd_data (rd_data)
    );

    brg_term_cnt #(.W(PC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (1'b1),
        .last    (presc_last(cfg.psel)),
        .hit     (pre_tick)
    );

    brg_term_cnt #(.W(DC_W)) u_pow2 (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (pre_tick),
        .last    (div_last(cfg.rsel)),
        .hit     (rx_en)
    );

    generate
        if (OVERSAMPLE > 1) begin : g_os
            brg_term_cnt #(.W(OS_W)) u_os (
                .clk     (clk),
                .rst     (rst),
                .restart (restart),
                .step    (rx_en),
                .last    (OS_W'(OVERSAMPLE - 1)),
                .hit     (tx_en)
            );
        end else begin : g_no_os
            assign tx_en = rx_en;
        end
    endgenerate

    AST_TX_ON_RX: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> rx_en); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_en); // R6

    AST_SINGLE_RX: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !wr_en && (cfg != '0)) |=> !rx_en); // R7

    AST_FASTEST_CONT: assert property (@(posedge clk) disable iff (rst)
        (rd_data == '0) |-> rx_en); // R8

endmodule

// File: tb/uart_rate_gen_test.sv
`timescale 1ns/1ps
module uart_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rx_en;
    logic       tx_en;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int rx_q[$];
    int tx_q[$];
    string cur_tag = "R4";

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_rate_gen uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rx_en   (rx_en),
        .tx_en   (tx_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // R3 divisor table, written independently of the design
    function automatic int pdiv(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 3;
            2'd2: return 4;
            default: return 13;
        endcase
    endfunction

    // anything still queued is a strobe that never arrived
    task automatic flush_missing();
        while (rx_q.size() > 0) begin
            check({cur_tag, " missing rx_en"}, -1, rx_q.pop_front());
        end
        while (tx_q.size() > 0) begin
            check("R5 missing tx_en", -1, tx_q.pop_front());
        end
    endtask

    // driver: write the byte, then queue every strobe expected within the window
    task automatic run_cfg(input logic [7:0] b, input int win, input string tag);
        int p;
        int base;
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        flush_missing();
        cur_tag = tag;
        base = cyc;
        p = pdiv(b[5:4]) << b[2:0];
        for (int m = 1; m * p <= win; m++) rx_q.push_back(base + m * p - 1);       // R6 R4
        for (int m = 1; 16 * m * p <= win; m++) tx_q.push_back(base + 16 * m * p - 1); // R5 R9
        mon_on = 1'b1;
        check("R1 readback", rd_data, b & 8'h37);
        repeat (win - 1) @(negedge clk);
    endtask

    // monitor: compare each strobe with the head of its queue
    always begin
        @(negedge clk);
        #1;
        if (mon_on) begin
            if (rx_en) begin
                if (rx_q.size() == 0) check({cur_tag, " R7 extra rx_en"}, cyc, -1);
                else check({cur_tag, " rx_en timing"}, cyc, rx_q.pop_front());
            end
            if (tx_en) begin
                if (tx_q.size() == 0) check("R5 extra tx_en", cyc, -1);
                else check("R5 tx_en timing", cyc, tx_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset readback", rd_data, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 R8 rx_en after reset", rx_en, 1);
        end
        run_cfg(8'h00, 40,    "R8");
        run_cfg(8'h10, 100,   "R3");
        run_cfg(8'h21, 300,   "R4");
        run_cfg(8'h30, 420,   "R3");
        run_cfg(8'h32, 900,   "R4");
        run_cfg(8'hC8, 37,    "R1");
        run_cfg(8'h07, 4200,  "R4");
        run_cfg(8'hFF, 53300, "R6");
        wr_en   = 1'b1;
        wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        flush_missing();
        mon_on = 1'b0;
        check("R1 readback final", rd_data, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule